// File: doc/BRIEF.md
# Two-Beat Burst SRAM with Independent Read and Write Ports

This block is an on-chip memory that moves data in fixed bursts of two words. Reads and writes use separate data buses, and one read and one write can start in the same burst period. A burst period lasts two cycles of a single beat-rate clock. The block drives a phase output, `beat_ph`, that marks which beat is current: beat A when it is 0, beat B when it is 1. Control strobes are sampled on beat A. Write data is taken on both beats. The write address is taken on beat B.

Each burst address selects a pair of words. Beat A carries the even word of the pair and beat B the odd word. The word is split into byte lanes, and each lane has an active-low write mask that is sampled separately on each beat. The lane width depends on `WORD_W`:

| `WORD_W` | Lanes | Lane width |
|---|---|---|
| 8 | 2 | 4 bits (nibbles) |
| 9 | 1 | 9 bits |
| 18 | 2 | 9 bits |
| 36 | 4 | 9 bits |

Read data comes back on `rdata` with a valid flag. Reset clears only the transaction state. The storage array is not initialised by reset.

Top module: `qb2_sram`

## Requirements
- R1: While `rst_n` is low, `rvalid` is 0, `rdata` is all zeros and `beat_ph` is 0.
- R2: After reset has been released, `beat_ph` changes value every clock cycle. Beat A (`beat_ph`=0) and beat B (`beat_ph`=1) alternate.
- R3: A low `rd_n` in a beat-A cycle starts a read of the pair at `addr`.
  - Two cycles later, in the next beat-A cycle, `rdata` holds the even word (word index `{addr,0}`).
  - In the following beat-B cycle, `rdata` holds the odd word (word index `{addr,1}`).
  - `rvalid` is 1 in exactly those two cycles.
- R4: A low `rd_n` in a beat-B cycle has no effect: `rvalid` stays 0 two cycles later.
- R5: A low `wr_n` in a beat-A cycle starts a write of one pair.
  - The `wdata` value in that beat-A cycle is stored to word `{A,0}`.
  - The `wdata` value in the next beat-B cycle is stored to word `{A,1}`.
  - A is the `addr` value in that beat-B cycle.
- R6: Lane i is bits `[i*LANE_W +: LANE_W]`. It is written only when `bw_n[i]` is 0 in the same beat as that lane's data; other lanes keep their contents. With `WORD_W`=36 there are four 9-bit lanes, and mask 4'hA writes lanes 0 and 2.
- R7: If a read and a write target the same pair in the same burst period, the read returns the contents from before that write.
- R8: When both `rd_n` and `wr_n` are high in beat A, `addr`, `wdata` and `bw_n` are ignored: no word changes and no read output follows.
- R9: The `addr` value in the beat-A cycle of a write is not used as the write address.
- R10: Reset leaves the stored words unchanged; a pair written before reset reads back the same after it.
- R11: Reads started in consecutive burst periods give a continuous run of `rvalid` with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock; two cycles form one burst period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| beat_ph | output | 1 | Current beat: 0 for beat A, 1 for beat B |
| addr | input | ADDR_W | Pair address: read address in beat A, write address in beat B |
| rd_n | input | 1 | Active-low read start, sampled in beat A |
| wr_n | input | 1 | Active-low write start, sampled in beat A |
| wdata | input | WORD_W | Write word: even word in beat A, odd word in beat B |
| bw_n | input | LANES | Active-low per-lane write masks, one set per beat |
| rdata | output | WORD_W | Read word: even word, then odd word |
| rvalid | output | 1 | High during the two beats that carry read data |

## Verification
A phase register that slips by one beat swaps the two words of every burst. It also moves `rvalid` onto a beat-B start, so the first read after reset exposes it. Capture registers that are not gated by beat show up within one burst:
- a write lands at the beat-A address;
- a masked lane is overwritten;
- a read shows the new data where the old data was expected.

A stuck pending-read flag is seen two cycles after any idle period, as a stray `rvalid`.

// File: rtl/qb2_pkg.sv
package qb2_pkg;

  typedef enum logic {
    BEAT_A = 1'b0,
    BEAT_B = 1'b1
  } beat_e;

  // Number of write lanes for a supported word width: the 8-bit word
  // uses nibble lanes, every other width uses 9-bit lanes.
  function automatic int lane_count(input int word_w);
    if (word_w == 8) return 2;
    return word_w / 9;
  endfunction

endpackage

// File: rtl/qb2_rst_sync.sv
module qb2_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sh_q[STAGES-1];

endmodule

// File: rtl/qb2_wr_capture.sv
module qb2_wr_capture #(
  parameter int WORD_W = 36,
  parameter int LANES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              beat_b,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  bw_n,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WORD_W-1:0] word0,
  output logic [LANES-1:0]  mask0_n,
  output logic [WORD_W-1:0] word1,
  output logic [LANES-1:0]  mask1_n
);

  logic              wr_go_q, wr_go_d;
  logic              cap_en;
  logic [WORD_W-1:0] w0_q;
  logic [LANES-1:0]  m0_q;

  assign cap_en = !beat_b;

  always_comb begin
    wr_go_d = wr_go_q;
    if (cap_en) wr_go_d = !wr_n;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) wr_go_q <= 1'b0;
    else        wr_go_q <= wr_go_d;
  end

  // First-beat data and masks, loaded only when a write starts.
  always_ff @(posedge clk) begin
    if (cap_en && !wr_n) begin
      w0_q <= wdata;
      m0_q <= bw_n;
    end
  end

  // The second beat commits the pair, using the address and data present now.
  assign commit      = beat_b && wr_go_q;
  assign commit_addr = addr;
  assign word0       = w0_q;
  assign mask0_n     = m0_q;
  assign word1       = wdata;
  assign mask1_n     = bw_n;

endmodule

// File: rtl/qb2_array.sv
module qb2_array #(
  parameter int WORD_W = 36,
  parameter int LANES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wd0,
  input  logic [LANES-1:0]  wm0_n,
  input  logic [WORD_W-1:0] wd1,
  input  logic [LANES-1:0]  wm1_n,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rd0,
  output logic [WORD_W-1:0] rd1
);

  localparam int LANE_W = WORD_W / LANES;
  localparam int WORDS  = 2 * (1 << ADDR_W);

  logic [ADDR_W:0] wi0, wi1, ri0, ri1;

  assign wi0 = {waddr, 1'b0};
  assign wi1 = {waddr, 1'b1};
  assign ri0 = {raddr, 1'b0};
  assign ri1 = {raddr, 1'b1};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
      if (we && !wm0_n[g]) mem[wi0] <= wd0[g*LANE_W +: LANE_W];
      if (we && !wm1_n[g]) mem[wi1] <= wd1[g*LANE_W +: LANE_W];
    end

    assign rd0[g*LANE_W +: LANE_W] = mem[ri0];
    assign rd1[g*LANE_W +: LANE_W] = mem[ri1];
  end

endmodule

// File: rtl/qb2_rd_pipe.sv
module qb2_rd_pipe #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              beat_b,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] rd0,
  input  logic [WORD_W-1:0] rd1,
  output logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  logic              rd_go_q, rd_go_d;
  logic              rvalid_q, rvalid_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic [WORD_W-1:0] hold_q;
  logic [ADDR_W-1:0] ra_q;
  logic              ra_en, hold_en;

  assign ra_en   = !beat_b && !rd_n;
  assign hold_en = beat_b && rd_go_q;

  always_comb begin
    rd_go_d  = rd_go_q;
    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    if (!beat_b) begin
      // Beat A edge: capture the request and advance to the odd word.
      rd_go_d = !rd_n;
      if (rvalid_q) rdata_d = hold_q;
    end else begin
      // Beat B edge: fetch both words of a pending read.
      rvalid_d = rd_go_q;
      if (rd_go_q) rdata_d = rd0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rd_go_q  <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rd_go_q  <= rd_go_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ra_en)   ra_q   <= addr;
    if (hold_en) hold_q <= rd1;
  end

  assign raddr  = ra_q;
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/qb2_sram.sv
module qb2_sram #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 6,
  localparam int LANES = qb2_pkg::lane_count(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              beat_ph,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  bw_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  import qb2_pkg::*;

  logic              rst_q;
  beat_e             ph_q, ph_d;
  logic              beat_b;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr, raddr;
  logic [WORD_W-1:0] word0, word1, rd0, rd1;
  logic [LANES-1:0]  mask0_n, mask1_n;

  qb2_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  always_comb begin
    ph_d = (ph_q == BEAT_A) ? BEAT_B : BEAT_A;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ph_q <= BEAT_A;
    else        ph_q <= ph_d;
  end

  assign beat_b  = (ph_q == BEAT_B);
  assign beat_ph = beat_b;

  qb2_wr_capture #(.WORD_W(WORD_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_wr (
    .clk         (clk),
    .rst_q       (rst_q),
    .beat_b      (beat_b),
    .wr_n        (wr_n),
    .addr        (addr),
    .wdata       (wdata),
    .bw_n        (bw_n),
    .commit      (commit),
    .commit_addr (commit_addr),
    .word0       (word0),
    .mask0_n     (mask0_n),
    .word1       (word1),
    .mask1_n     (mask1_n)
  );

  qb2_array #(.WORD_W(WORD_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (commit),
    .waddr (commit_addr),
    .wd0   (word0),
    .wm0_n (mask0_n),
    .wd1   (word1),
    .wm1_n (mask1_n),
    .raddr (raddr),
    .rd0   (rd0),
    .rd1   (rd1)
  );

  qb2_rd_pipe #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rd (
    .clk    (clk),
    .rst_q  (rst_q),
    .beat_b (beat_b),
    .rd_n   (rd_n),
    .addr   (addr),
    .rd0    (rd0),
    .rd1    (rd1),
    .raddr  (raddr),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

endmodule

// File: rtl/qb2_sram_chk.sv
module qb2_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_int,
  input logic              beat_ph,
  input logic              rd_n,
  input logic [WORD_W-1:0] rdata,
  input logic              rvalid
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!rvalid && rdata == '0 && !beat_ph);
    end
  end

  assert_beat_toggle_R2: assert property (@(posedge clk) disable iff (!rst_int)
    $past(rst_int) |-> (beat_ph != $past(beat_ph)));

  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_int)
    (!rd_n && !beat_ph) |-> ##2 (rvalid && !beat_ph));

  assert_pair_length_R3: assert property (@(posedge clk) disable iff (!rst_int)
    (rvalid && !beat_ph) |=> rvalid);

  assert_start_on_beat_a_R3: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(rvalid) |-> !beat_ph);

  assert_no_phantom_read_R8: assert property (@(posedge clk) disable iff (!rst_int)
    (rd_n && !beat_ph) |-> ##2 !rvalid);

endmodule

bind qb2_sram qb2_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_int (rst_q),
  .beat_ph (beat_ph),
  .rd_n    (rd_n),
  .rdata   (rdata),
  .rvalid  (rvalid)
);

// File: tb/sim_qb2_sram.sv
`timescale 1ns/1ps
module sim_qb2_sram;

  localparam int W  = 36;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int NV = 14;

  typedef struct packed {
    logic          rd;
    logic          wr;
    logic [AW-1:0] ra;
    logic [AW-1:0] wa;
    logic [W-1:0]  d0;
    logic [W-1:0]  d1;
    logic [LN-1:0] m0;
    logic [LN-1:0] m1;
  } vec_t;

  // rd, wr, beat-A addr, beat-B addr, word0, word1, mask0, mask1
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 6'd0,  6'd5,  36'h123456789, 36'hABCDEF012, 4'h0, 4'h0}, // R5 full write
    '{1'b0, 1'b1, 6'd0,  6'd20, 36'h0F0F0F0F0, 36'h111122223, 4'h0, 4'h0}, // R5
    '{1'b1, 1'b1, 6'd5,  6'd9,  36'h555555555, 36'h999999999, 4'h0, 4'h0}, // R3 read with write
    '{1'b1, 1'b0, 6'd9,  6'd0,  36'h0,         36'h0,         4'hF, 4'hF}, // R11 back-to-back
    '{1'b0, 1'b1, 6'd0,  6'd5,  36'hFFFFFFFFF, 36'h000000000, 4'hA, 4'h5}, // R6 per-beat masks
    '{1'b1, 1'b0, 6'd5,  6'd0,  36'h0,         36'h0,         4'hF, 4'hF}, // R6 readback
    '{1'b1, 1'b1, 6'd9,  6'd9,  36'h2468ACE13, 36'h13579BDF0, 4'h0, 4'h0}, // R7 same pair
    '{1'b1, 1'b0, 6'd9,  6'd0,  36'h0,         36'h0,         4'hF, 4'hF}, // R7 new data
    '{1'b0, 1'b0, 6'd5,  6'd5,  36'hDEADBEEF0, 36'hCAFEF00D1, 4'h0, 4'h0}, // R8 deselected
    '{1'b1, 1'b0, 6'd5,  6'd0,  36'h0,         36'h0,         4'hF, 4'hF}, // R8 unchanged
    '{1'b0, 1'b1, 6'd20, 6'd33, 36'h777777777, 36'h888888888, 4'h0, 4'h0}, // R9 beat-B address
    '{1'b1, 1'b0, 6'd20, 6'd0,  36'h0,         36'h0,         4'hF, 4'hF}, // R9 20 untouched
    '{1'b1, 1'b0, 6'd33, 6'd0,  36'h0,         36'h0,         4'hF, 4'hF}, // R9 33 written
    '{1'b0, 1'b0, 6'd0,  6'd0,  36'h0,         36'h0,         4'hF, 4'hF}  // flush
  };

  logic          clk;
  logic          rst_n;
  logic          beat_ph;
  logic [AW-1:0] addr;
  logic          rd_n, wr_n;
  logic [W-1:0]  wdata;
  logic [LN-1:0] bw_n;
  logic [W-1:0]  rdata;
  logic          rvalid;

  qb2_sram #(.WORD_W(W), .ADDR_W(AW)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat_ph (beat_ph),
    .addr    (addr),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .wdata   (wdata),
    .bw_n    (bw_n),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] model [2**(AW+1)];
  int           checks = 0;
  int           errors = 0;
  logic         pend = 1'b0;
  logic [W-1:0] e0, e1;
  bit           done = 1'b0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                         input logic [LN-1:0] m_n);
    logic [W-1:0] r;
    r = old;
    for (int i = 0; i < LN; i++)
      if (!m_n[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic align();
    @(negedge clk);
    while (beat_ph !== 1'b0) @(negedge clk);
  endtask

  // Called at a beat-A negedge; returns at the next beat-A negedge.
  task automatic run_period(input vec_t v, input logic stray_rd, input string tag);
    logic [W-1:0] n0, n1;
    if (pend) begin
      chk({tag, " R3 rvalid word0"}, W'(rvalid), W'(1));
      chk({tag, " R3 even word"}, rdata, e0);
    end else begin
      chk({tag, " R8 R4 no read output"}, W'(rvalid), W'(0));
    end
    rd_n  = !v.rd;
    wr_n  = !v.wr;
    addr  = v.ra;
    wdata = v.d0;
    bw_n  = v.m0;
    @(negedge clk);
    if (pend) begin
      chk({tag, " R3 rvalid word1"}, W'(rvalid), W'(1));
      chk({tag, " R3 odd word"}, rdata, e1);
    end
    rd_n  = !stray_rd;
    wr_n  = 1'b1;
    addr  = v.wa;
    wdata = v.d1;
    bw_n  = v.m1;
    n0 = model[{v.ra, 1'b0}];
    n1 = model[{v.ra, 1'b1}];
    pend = v.rd;
    e0 = n0;
    e1 = n1;
    if (v.wr) begin
      model[{v.wa, 1'b0}] = merge(model[{v.wa, 1'b0}], v.d0, v.m0);
      model[{v.wa, 1'b1}] = merge(model[{v.wa, 1'b1}], v.d1, v.m1);
    end
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    vec_t v;
    rst_n = 1'b1;
    rd_n  = 1'b1;
    wr_n  = 1'b1;
    addr  = '0;
    wdata = '0;
    bw_n  = '1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk("R1 rvalid in reset", W'(rvalid), W'(0));
    chk("R1 rdata in reset", rdata, '0);
    chk("R1 beat_ph in reset", W'(beat_ph), W'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    align();
    // R2: alternating beats
    chk("R2 beat A", W'(beat_ph), W'(0));
    @(negedge clk);
    chk("R2 beat B", W'(beat_ph), W'(1));
    @(negedge clk);
    chk("R2 beat A again", W'(beat_ph), W'(0));

    for (int i = 0; i < NV; i++) run_period(VEC[i], 1'b0, $sformatf("vec%0d", i));

    // R4: read strobe only in beat B, then an idle period checks no output
    v = '{1'b0, 1'b0, 6'd5, 6'd5, 36'h0, 36'h0, 4'hF, 4'hF};
    run_period(v, 1'b1, "R4 stray strobe");
    run_period(v, 1'b0, "R4 after stray");
    run_period(v, 1'b0, "R4 settle");

    // R10: contents survive reset
    v = '{1'b0, 1'b1, 6'd0, 6'd40, 36'h3C3C3C3C3, 36'hC3C3C3C3C, 4'h0, 4'h0};
    run_period(v, 1'b0, "R10 write");
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 R10 rvalid in reset", W'(rvalid), W'(0));
    chk("R1 R10 rdata in reset", rdata, '0);
    pend = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    align();
    v = '{1'b1, 1'b0, 6'd40, 6'd0, 36'h0, 36'h0, 4'hF, 4'hF};
    run_period(v, 1'b0, "R10 read after reset");
    v = '{1'b0, 1'b0, 6'd0, 6'd0, 36'h0, 36'h0, 4'hF, 4'hF};
    run_period(v, 1'b0, "R10 flush");
    run_period(v, 1'b0, "R10 idle");

    done = 1'b1;
    summary();
  end

endmodule